// File: doc/BRIEF.md
# Triggered Clock Glitch Generator

The block derives a target clock for a device under test from a fast reference clock by counting reference ticks. One nominal target period lasts `NOM_TICKS` reference ticks, so a reference clock ten times faster than the target clock gives steps of one tenth of a period. With the nominal 24 MHz target period of about 41.7 ns, a tick lands in the few-nanosecond range. That is the step size of the glitch period.

A controller first arms the block. It then waits for a rising edge on an external trigger. A programmed number of whole target cycles later, it replaces one target period with two shorter ones. An extra rising edge is placed `G` ticks after the start of that cycle, and the remaining `NOM_TICKS - G` ticks run until the next regular edge. Exactly one such glitch is produced per arm. A one-tick strobe marks the inserted edge, so neighbouring logic such as a supply-dip switch can align to it. A done flag then stays high until the block is armed again.

Top module: `glitch_clkgen`

## Requirements
- R1: While reset is asserted, `tgt_clk_o`, `glitch_stb_o` and `done_o` are all low.
- R2: Outside a glitch cycle, `tgt_clk_o` rises every `NOM_TICKS` reference ticks and stays high for `NOM_TICKS/2` ticks of each period.
- R3: A trigger edge seen while the block is not armed (after reset, or after a glitch with no new arm) produces no strobe and leaves the clock at its nominal period.
- R4: Only a low-to-high transition of the synchronized trigger is accepted. A trigger already high when the block is armed does nothing until it falls and rises again.
- R5: The trigger is synchronized through `SYNC_STAGES` flops and acted on one tick later. The glitch cycle is then the (D+1)-th target cycle that begins strictly after that tick, where D is `dly_cycles_i` captured at that tick. Measured at the ports, a trigger raised k ticks after an observed rising edge of `tgt_clk_o` is followed by (k+SYNC_STAGES+2)/NOM_TICKS + 1 + D regular rising edges (integer division), and then the strobe.
- R6: In the glitch cycle, an extra rising edge of `tgt_clk_o` appears G ticks after the cycle's regular rising edge, and the next regular rising edge follows `NOM_TICKS - G` ticks after the extra one.
- R7: The glitch period G is `glitch_ticks_i` captured with the trigger, clamped to the range 2 to `NOM_TICKS-2`. A value below 2 acts as 2, and a value above `NOM_TICKS-2` acts as `NOM_TICKS-2`.
- R8: `glitch_stb_o` is high for exactly one tick, in the same tick in which `tgt_clk_o` shows the inserted rising edge. It is high only inside a glitch cycle.
- R9: `done_o` is low until the glitch cycle ends. It is high by the next regular rising edge after the glitch and stays high until `arm_i` is asserted, which clears it.
- R10: After a glitch, further triggers produce no strobe until the block is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock; all timing is counted in its ticks |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Arms the block when it is idle or done; clears done |
| trig_i | input | 1 | Asynchronous trigger; its rising edge starts the delay count |
| dly_cycles_i | input | DLY_W | Whole target cycles between trigger and glitch cycle |
| glitch_ticks_i | input | PH_W | Glitch period in reference ticks (clamped) |
| tgt_clk_o | output | 1 | Target clock for the device under test |
| glitch_stb_o | output | 1 | One-tick strobe aligned with the inserted rising edge |
| done_o | output | 1 | High after the single glitch until re-armed |

## Verification
On every cycle, the assertions check these properties: the strobe lasts one tick, it coincides with a fresh rising edge of the target clock, and it occurs only inside the glitch cycle. They also check that done holds until an arm and that no strobe appears while idle, armed or done. Other behaviours need a full scenario and are checked by the bench: the exact count of regular edges between trigger and glitch for every trigger phase, the glitch and remainder periods for every programmed glitch value including the clamped ones, and the ignored-trigger cases. The bench sweeps the trigger phase over a whole target period against several delays, and the glitch value over its full input range.

// File: rtl/glitch_clkgen_pkg.sv
package glitch_clkgen_pkg;
   typedef enum logic [2:0] {
      GS_IDLE   = 3'd0,
      GS_ARMED  = 3'd1,
      GS_WAIT   = 3'd2,
      GS_GLITCH = 3'd3,
      GS_DONE   = 3'd4
   } gstate_t;
endpackage

// File: rtl/gclk_trig_sync.sv
module gclk_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   output logic rise_o
);
   // STAGES synchronizer flops plus one history flop for edge detection
   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], trig_i};
   end

   assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/gclk_phase.sv
module gclk_phase #(
   parameter int NOM_TICKS = 10,
   localparam int PH_W = $clog2(NOM_TICKS)
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [PH_W-1:0] ph_o,
   output logic            wrap_o
);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(NOM_TICKS - 1);

   assign wrap_o = (ph_o == PH_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ph_o <= '0;
      else if (wrap_o) ph_o <= '0;
      else             ph_o <= ph_o + 1'b1;
   end
endmodule

// File: rtl/gclk_seq.sv
module gclk_seq
   import glitch_clkgen_pkg::*;
#(
   parameter int NOM_TICKS = 10,
   parameter int DLY_W     = 4,
   localparam int PH_W     = $clog2(NOM_TICKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic             rise_i,
   input  logic             wrap_i,
   input  logic [DLY_W-1:0] dly_i,
   input  logic [PH_W-1:0]  gin_i,
   output gstate_t          state_o,
   output logic [PH_W-1:0]  g_o,
   output logic             gl_o,
   output logic             done_o
);
   localparam logic [PH_W-1:0] G_MIN = PH_W'(2);
   localparam logic [PH_W-1:0] G_MAX = PH_W'(NOM_TICKS - 2);

   logic [DLY_W-1:0] cnt;
   logic [PH_W-1:0]  g_clamped;

   always_comb begin
      if (gin_i < G_MIN)      g_clamped = G_MIN;
      else if (gin_i > G_MAX) g_clamped = G_MAX;
      else                    g_clamped = gin_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_o <= GS_IDLE;
         cnt     <= '0;
         g_o     <= G_MIN;
      end else begin
         case (state_o)
            GS_IDLE, GS_DONE: if (arm_i) state_o <= GS_ARMED;
            GS_ARMED: if (rise_i) begin
               state_o <= GS_WAIT;
               cnt     <= dly_i;
               g_o     <= g_clamped;
            end
            GS_WAIT: if (wrap_i) begin
               if (cnt == '0) state_o <= GS_GLITCH;
               else           cnt     <= cnt - 1'b1;
            end
            GS_GLITCH: if (wrap_i) state_o <= GS_DONE;
            default: state_o <= GS_IDLE;
         endcase
      end
   end

   assign gl_o   = (state_o == GS_GLITCH);
   assign done_o = (state_o == GS_DONE);
endmodule

// File: rtl/gclk_shaper.sv
module gclk_shaper #(
   parameter int NOM_TICKS = 10,
   localparam int PH_W = $clog2(NOM_TICKS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PH_W-1:0] ph_i,
   input  logic            gl_i,
   input  logic [PH_W-1:0] g_i,
   output logic            tclk_o,
   output logic            stb_o
);
   localparam logic [PH_W:0] NOM_X  = (PH_W+1)'(NOM_TICKS);
   localparam logic [PH_W:0] HALF_X = (PH_W+1)'(NOM_TICKS / 2);

   logic [PH_W:0] ph_x, g_x, rem_x, end2_x;
   logic          lvl, ins;

   always_comb begin
      ph_x   = {1'b0, ph_i};
      g_x    = {1'b0, g_i};
      rem_x  = NOM_X - g_x;
      end2_x = g_x + (rem_x >> 1);
      if (gl_i)
         lvl = (ph_x < (g_x >> 1)) || ((ph_x >= g_x) && (ph_x < end2_x));
      else
         lvl = (ph_x < HALF_X);
      ins = gl_i && (ph_x == g_x);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tclk_o <= 1'b0;
         stb_o  <= 1'b0;
      end else begin
         tclk_o <= lvl;
         stb_o  <= ins;
      end
   end
endmodule

// File: rtl/glitch_clkgen.sv
module glitch_clkgen
   import glitch_clkgen_pkg::*;
#(
   parameter int NOM_TICKS   = 10,
   parameter int DLY_W       = 4,
   parameter int SYNC_STAGES = 2,
   localparam int PH_W       = $clog2(NOM_TICKS)
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic             trig_i,
   input  logic [DLY_W-1:0] dly_cycles_i,
   input  logic [PH_W-1:0]  glitch_ticks_i,
   output logic             tgt_clk_o,
   output logic             glitch_stb_o,
   output logic             done_o
);
   if (NOM_TICKS < 4) begin : g_bad_nom
      $error("glitch_clkgen: NOM_TICKS must be at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("glitch_clkgen: SYNC_STAGES must be at least 2");
   end
   if (DLY_W < 1) begin : g_bad_dly
      $error("glitch_clkgen: DLY_W must be at least 1");
   end

   logic            trig_rise;
   logic [PH_W-1:0] ph;
   logic            wrap;
   logic [PH_W-1:0] g_cur;
   logic            in_glitch;
   gstate_t         seq_state;

   gclk_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk_ref), .rst_n(rst_n), .trig_i(trig_i), .rise_o(trig_rise)
   );

   gclk_phase #(.NOM_TICKS(NOM_TICKS)) u_phase (
      .clk(clk_ref), .rst_n(rst_n), .ph_o(ph), .wrap_o(wrap)
   );

   gclk_seq #(.NOM_TICKS(NOM_TICKS), .DLY_W(DLY_W)) u_seq (
      .clk(clk_ref), .rst_n(rst_n), .arm_i(arm_i), .rise_i(trig_rise),
      .wrap_i(wrap), .dly_i(dly_cycles_i), .gin_i(glitch_ticks_i),
      .state_o(seq_state), .g_o(g_cur), .gl_o(in_glitch), .done_o(done_o)
   );

   gclk_shaper #(.NOM_TICKS(NOM_TICKS)) u_shaper (
      .clk(clk_ref), .rst_n(rst_n), .ph_i(ph), .gl_i(in_glitch),
      .g_i(g_cur), .tclk_o(tgt_clk_o), .stb_o(glitch_stb_o)
   );
endmodule

// File: rtl/glitch_clkgen_chk.sv
module glitch_clkgen_chk
   import glitch_clkgen_pkg::*;
(
   input logic    clk_i,
   input logic    rst_n,
   input logic    arm_i,
   input logic    tclk_i,
   input logic    stb_i,
   input logic    done_i,
   input gstate_t st_i
);
   // R8: strobe lasts one tick
   a_r8_stb_one_tick: assert property (@(posedge clk_i) disable iff (!rst_n)
      stb_i |=> !stb_i);

   // R8: strobe coincides with a fresh rising edge of the target clock
   a_r8_stb_on_rise: assert property (@(posedge clk_i) disable iff (!rst_n)
      stb_i |-> (tclk_i && !$past(tclk_i)));

   // R8: strobe only inside the glitch cycle
   a_r8_stb_in_glitch: assert property (@(posedge clk_i) disable iff (!rst_n)
      stb_i |-> (st_i == GS_GLITCH));

   // R9: done holds until arm
   a_r9_done_holds: assert property (@(posedge clk_i) disable iff (!rst_n)
      (done_i && !arm_i) |=> done_i);

   // R10: no strobe once done
   a_r10_no_stb_done: assert property (@(posedge clk_i) disable iff (!rst_n)
      done_i |-> !stb_i);

   // R3: no strobe while idle or waiting for the trigger
   a_r3_no_stb_unarmed: assert property (@(posedge clk_i) disable iff (!rst_n)
      ((st_i == GS_IDLE) || (st_i == GS_ARMED)) |-> !stb_i);
endmodule

bind glitch_clkgen glitch_clkgen_chk u_chk (
   .clk_i(clk_ref), .rst_n(rst_n), .arm_i(arm_i), .tclk_i(tgt_clk_o),
   .stb_i(glitch_stb_o), .done_i(done_o), .st_i(seq_state)
);

// File: tb/glitch_clkgen_tb.sv
module glitch_clkgen_tb;
   localparam int T    = 10;
   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       arm_i = 1'b0;
   logic       trig_i = 1'b0;
   logic [3:0] dly_cycles_i = '0;
   logic [3:0] glitch_ticks_i = 4'd4;
   logic       tgt_clk_o, glitch_stb_o, done_o;

   int  checks = 0;
   int  fails  = 0;
   int  cyc    = 0;
   int  stb_cnt = 0;
   bit  prev_clk = 1'b0;
   bit  rise = 1'b0;

   always #4 clk = ~clk;

   glitch_clkgen #(.NOM_TICKS(T), .DLY_W(4), .SYNC_STAGES(SYNC)) u_dut (
      .clk_ref(clk), .rst_n(rst_n), .arm_i(arm_i), .trig_i(trig_i),
      .dly_cycles_i(dly_cycles_i), .glitch_ticks_i(glitch_ticks_i),
      .tgt_clk_o(tgt_clk_o), .glitch_stb_o(glitch_stb_o), .done_o(done_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      prev_clk = tgt_clk_o;
      @(negedge clk);
      cyc++;
      rise = tgt_clk_o & ~prev_clk;
      if (glitch_stb_o) stb_cnt++;
   endtask

   task automatic wait_rise(output int n);
      n = 0;
      do begin
         step();
         n++;
      end while (!rise && n < 100);
   endtask

   // R2: nominal period and high time
   task automatic check_nominal();
      int n, hi;
      wait_rise(n);
      hi = 0;
      while (tgt_clk_o && hi < 100) begin step(); hi++; end
      n = hi;
      while (!rise && n < 100) begin step(); n++; end
      chk(hi == T/2, "R2", "high width", hi, T/2);
      chk(n == T, "R2", "period", n, T);
   endtask

   task automatic run_glitch(input bit do_arm, input int k, input int d,
                             input int gin, input string greq);
      int n, nr, last, exp_g, exp_n;
      bit found;
      exp_g = (gin < 2) ? 2 : ((gin > T-2) ? T-2 : gin);
      exp_n = (k + SYNC + 2) / T + 1 + d;
      dly_cycles_i   = 4'(d);
      glitch_ticks_i = 4'(gin);
      if (do_arm) begin
         arm_i = 1'b1; step(); arm_i = 1'b0;
      end
      wait_rise(n);
      last = cyc;
      repeat (k) step();
      trig_i = 1'b1;
      nr = 0; found = 1'b0;
      for (int i = 0; i < 40*T && !found; i++) begin
         step();
         if (glitch_stb_o) found = 1'b1;
         else if (rise) begin nr++; last = cyc; end
      end
      chk(found, "R5", "strobe seen", int'(found), 1);
      if (found) begin
         chk(rise, "R8", "strobe on inserted rising edge", int'(rise), 1);
         chk(nr == exp_n, "R5", "regular edges before glitch", nr, exp_n);
         chk(cyc - last == exp_g, greq, "glitch period", cyc - last, exp_g);
         chk(!done_o, "R9", "done low during glitch", int'(done_o), 0);
         step();
         chk(!glitch_stb_o, "R8", "strobe one tick", int'(glitch_stb_o), 0);
         wait_rise(n);
         chk(n + 1 == T - exp_g, "R6", "remainder period", n + 1, T - exp_g);
         chk(done_o, "R9", "done after glitch", int'(done_o), 1);
      end
      trig_i = 1'b0;
      repeat (SYNC + 2) step();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!tgt_clk_o && !glitch_stb_o && !done_o, "R1", "outputs in reset",
          int'({tgt_clk_o, glitch_stb_o, done_o}), 0);
      rst_n = 1'b1;
      check_nominal();

      // R3: trigger while idle
      stb_cnt = 0;
      trig_i = 1'b1; repeat (3) step(); trig_i = 1'b0;
      repeat (4*T) step();
      chk(stb_cnt == 0, "R3", "strobes while unarmed", stb_cnt, 0);
      check_nominal();

      // R5/R6: trigger phase sweep against delays
      for (int d = 0; d < 3; d++)
         for (int k = 0; k < T; k++)
            run_glitch(1'b1, k, d, 4, "R6");

      // R7: glitch value sweep over full input range, clamps included
      for (int g = 0; g < 16; g++)
         run_glitch(1'b1, 3, 1, g, (g < 2 || g > T-2) ? "R7" : "R6");

      // R10: trigger after done
      stb_cnt = 0;
      trig_i = 1'b1; repeat (5*T) step(); trig_i = 1'b0;
      chk(stb_cnt == 0, "R10", "strobes after done", stb_cnt, 0);
      chk(done_o, "R10", "done held", int'(done_o), 1);
      check_nominal();

      // R4: trigger high before arming is not an edge
      trig_i = 1'b1; repeat (SYNC + 2) step();
      stb_cnt = 0;
      arm_i = 1'b1; step(); arm_i = 1'b0;
      step();
      chk(!done_o, "R9", "arm clears done", int'(done_o), 1'b0);
      repeat (5*T) step();
      chk(stb_cnt == 0, "R4", "held trigger ignored", stb_cnt, 0);
      trig_i = 1'b0; repeat (SYNC + 2) step();
      run_glitch(1'b0, 5, 2, 6, "R6");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule